// File: doc/BRIEF.md
# ADC Power and Enable Controller

This block is the register-side control engine of a successive-approximation ADC. Software reaches it over a plain 32-bit register port (address, write strobe, write data, combinational read data). Through it, software leaves deep power-down and turns on the voltage regulator. It can also set the boost bit, enable and disable the converter with a ready handshake, start and stop conversion activity, and run self-calibration.

The analog core is not present. Counters stand in for it and model, in clock cycles, the startup delay, the disable delay, the stop delay and the two calibration lengths. All of these are parameters, so a test can shorten them. Several command bits can only be set by software. Each stays high while its hardware action runs and is cleared only by the hardware.

The control register is at offset 0x08 and the status register is at offset 0x00. Each command is accepted only when the controller is idle, meaning no startup, calibration, disable or stop countdown is running.

Top module: `adc_pwr_ctl`

## Requirements
- R1: After reset the control register (0x08) reads 0x2000_0000: only deep power-down (bit 29) is set. The status register (0x00) reads 0.
- R2: Deep power-down (bit 29) and regulator enable (bit 28) are read/write. Writing bit 29 = 1 forces bit 28 to 0 in the same write. Bit 28 can only read 1 after a write with bit 28 = 1 and bit 29 = 0.
- R3: Boost (bit 8) is a plain read/write bit.
- R4: Writing enable (bit 0) = 1 is accepted only when bit 28 = 1 and bit 29 = 0 and the converter is disabled. An accepted enable sets bit 0. Ready (status bit 0) becomes 1 exactly STARTUP_CYC cycles after the write. Writing 1 to status bit 0 clears ready.
- R5: Writing disable (bit 1) = 1 is accepted only when the converter is enabled, idle and not started. Bits 0 and 1 then both read 1 for DISABLE_CYC cycles. After that both read 0 and ready is cleared.
- R6: Writing start (bit 2) = 1 is accepted only when the converter is enabled and idle. Writing stop (bit 4) = 1 is accepted only while start is set. After an accepted stop, bits 2 and 4 read 1 for STOP_CYC cycles and then both read 0.
- R7: Writing calibration start (bit 31) = 1 sets it. It clears itself OFS_CAL_CYC cycles later when linear-calibration select (bit 16) is 0. It clears itself after the larger of LIN_CAL_CYC and OFS_CAL_CYC when bit 16 is 1. Bits 16 and 30 are frozen while calibration runs.
- R8: A calibration request is ignored while the converter is enabled, or while bit 28 = 0 or bit 29 = 1.
- R9: Writing 0 to bits 31, 4, 2, 1 or 0 never clears them. Only the hardware clears these bits.
- R10: An enable request is ignored while bit 29 = 1 or bit 28 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the bus and the modelled converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume that the bus performs at most one write per cycle and that every delay parameter is at least 1. They also assume that software never removes regulator power while the converter is enabled. The stimulus keeps within these limits:
- It writes through a task that holds the strobe for exactly one edge.
- It leaves deep power-down or turns the regulator off only while the converter is disabled.
- It uses shortened delays in which linear calibration is longer than offset calibration, so the two calibration lengths can be told apart.

// File: rtl/adc_pwr_ctl.sv
module adc_pwr_ctl #(
  parameter int ADDR_W      = 8,
  parameter int STARTUP_CYC = 64,
  parameter int DISABLE_CYC = 4,
  parameter int STOP_CYC    = 4,
  parameter int OFS_CAL_CYC = 20,
  parameter int LIN_CAL_CYC = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h08);
  localparam int LONG_CAL = (LIN_CAL_CYC > OFS_CAL_CYC) ? LIN_CAL_CYC : OFS_CAL_CYC;
  localparam int M1 = (STARTUP_CYC > DISABLE_CYC) ? STARTUP_CYC : DISABLE_CYC;
  localparam int M2 = (M1 > STOP_CYC) ? M1 : STOP_CYC;
  localparam int CNT_MAX = (M2 > LONG_CAL) ? M2 : LONG_CAL;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  localparam int B_CAL = 31, B_DIF = 30, B_DPD = 29, B_VREG = 28;
  localparam int B_LIN = 16, B_BOOST = 8, B_STOP = 4, B_START = 2;
  localparam int B_DIS = 1, B_EN = 0;

  typedef enum logic [2:0] {PH_IDLE, PH_BOOT, PH_CAL, PH_OFF, PH_HALT} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic dpd, vreg, boost, dif_sel, lin_sel;
  logic cal, en, dis, run, halt, ready;

  wire wr_ctrl  = bus_wr && (bus_addr == CTRL_ADDR);
  wire wr_stat  = bus_wr && (bus_addr == STAT_ADDR);
  wire pwr_ok   = vreg && !dpd;
  wire idle     = (phase == PH_IDLE);
  wire cnt_last = !idle && (cnt == CNT_W'(1));

  wire req_en   = wr_ctrl && bus_wdata[B_EN] && idle && pwr_ok && !en;
  wire req_cal  = wr_ctrl && bus_wdata[B_CAL] && idle && pwr_ok && !en && !req_en;
  wire req_run  = wr_ctrl && bus_wdata[B_START] && idle && en && !run;
  wire req_dis  = wr_ctrl && bus_wdata[B_DIS] && idle && en && !run && !req_run;
  wire req_halt = wr_ctrl && bus_wdata[B_STOP] && idle && run;

  wire lin_next = (wr_ctrl && phase != PH_CAL) ? bus_wdata[B_LIN] : lin_sel;
  wire [CNT_W-1:0] cal_len = lin_next ? CNT_W'(LONG_CAL) : CNT_W'(OFS_CAL_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpd <= 1'b1; vreg <= 1'b0; boost <= 1'b0;
      dif_sel <= 1'b0; lin_sel <= 1'b0;
    end else if (wr_ctrl) begin
      dpd   <= bus_wdata[B_DPD];
      vreg  <= bus_wdata[B_VREG] && !bus_wdata[B_DPD];
      boost <= bus_wdata[B_BOOST];
      if (phase != PH_CAL) begin
        dif_sel <= bus_wdata[B_DIF];
        lin_sel <= bus_wdata[B_LIN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0;
      cal <= 1'b0; en <= 1'b0; dis <= 1'b0; run <= 1'b0; halt <= 1'b0;
      ready <= 1'b0;
    end else begin
      if (wr_stat && bus_wdata[0]) ready <= 1'b0;
      if (idle) begin
        if (req_en) begin
          en <= 1'b1; phase <= PH_BOOT; cnt <= CNT_W'(STARTUP_CYC);
        end else if (req_cal) begin
          cal <= 1'b1; phase <= PH_CAL; cnt <= cal_len;
        end else if (req_dis) begin
          dis <= 1'b1; phase <= PH_OFF; cnt <= CNT_W'(DISABLE_CYC);
        end else if (req_run) begin
          run <= 1'b1;
        end else if (req_halt) begin
          halt <= 1'b1; phase <= PH_HALT; cnt <= CNT_W'(STOP_CYC);
        end
      end else if (cnt_last) begin
        phase <= PH_IDLE;
        cnt   <= '0;
        case (phase)
          PH_BOOT: ready <= 1'b1;
          PH_CAL:  cal <= 1'b0;
          PH_OFF:  begin en <= 1'b0; dis <= 1'b0; ready <= 1'b0; end
          PH_HALT: begin run <= 1'b0; halt <= 1'b0; end
          default: ;
        endcase
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR) begin
      bus_rdata[0] = ready;
    end else if (bus_addr == CTRL_ADDR) begin
      bus_rdata[B_CAL]   = cal;
      bus_rdata[B_DIF]   = dif_sel;
      bus_rdata[B_DPD]   = dpd;
      bus_rdata[B_VREG]  = vreg;
      bus_rdata[B_LIN]   = lin_sel;
      bus_rdata[B_BOOST] = boost;
      bus_rdata[B_STOP]  = halt;
      bus_rdata[B_START] = run;
      bus_rdata[B_DIS]   = dis;
      bus_rdata[B_EN]    = en;
    end
  end

  assert_vreg_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> !vreg);
  assert_ready_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> en);
  assert_dis_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> en);
  assert_en_falls_after_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past(dis));
  assert_stop_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> run);
  assert_start_falls_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(halt));
  assert_cal_only_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal |-> !en);
  assert_cal_clears_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal) |-> $past(phase == PH_CAL && cnt == CNT_W'(1)));
endmodule

// File: tb/adc_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module adc_pwr_ctl_tb_top;
  localparam int STARTUP = 8, DISC = 4, STOPC = 3, OFS = 20, LIN = 200;
  localparam logic [7:0] CTRL = 8'h08, STAT = 8'h00;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_pwr_ctl #(.ADDR_W(8), .STARTUP_CYC(STARTUP), .DISABLE_CYC(DISC),
    .STOP_CYC(STOPC), .OFS_CAL_CYC(OFS), .LIN_CAL_CYC(LIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // {write data to control, expected control readback}
  localparam logic [63:0] VEC [0:8] = '{
    {32'h0000_0100, 32'h0000_0100},  // R2 R3 leave power-down, boost on
    {32'h1000_0100, 32'h1000_0100},  // R2 regulator on
    {32'h3000_0000, 32'h2000_0000},  // R2 power-down forces regulator off
    {32'h3000_0001, 32'h2000_0000},  // R10 enable ignored in power-down
    {32'h0000_0001, 32'h0000_0000},  // R10 enable ignored, regulator off
    {32'h8000_0000, 32'h0000_0000},  // R8 calibration ignored, regulator off
    {32'h1000_0000, 32'h1000_0000},  // R2 regulator on
    {32'h1001_0100, 32'h1001_0100},  // R3 boost and mode bit read back
    {32'h1000_0000, 32'h1000_0000}   // R3 boost cleared
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.2;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%08h expected=%08h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 reset control", CTRL, 32'h2000_0000);
    check("R1 reset status", STAT, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(CTRL, VEC[i][63:32]);
      check("R2/R3/R8/R10 vector", CTRL, VEC[i][31:0]);
    end

    // R7 offset calibration, R9 zero-write during calibration
    wr(CTRL, 32'h9000_0000);
    check("R7 cal set", CTRL, 32'h9000_0000);
    wr(CTRL, 32'h1001_0000);
    check("R9 cal kept, R7 mode frozen", CTRL, 32'h9000_0000);
    wait_cyc(OFS - 2);
    check("R7 offset cal still running", CTRL, 32'h9000_0000);
    wait_cyc(1);
    check("R7 offset cal done", CTRL, 32'h1000_0000);

    // R7 linear calibration
    wr(CTRL, 32'h9001_0000);
    wait_cyc(OFS);
    check("R7 linear cal past offset length", CTRL, 32'h9001_0000);
    wait_cyc(LIN - 1 - OFS);
    check("R7 linear cal still running", CTRL, 32'h9001_0000);
    wait_cyc(1);
    check("R7 linear cal done", CTRL, 32'h1001_0000);

    // R4 enable and startup
    wr(CTRL, 32'h1000_0001);
    check("R4 enable set", CTRL, 32'h1000_0001);
    wait_cyc(STARTUP - 1);
    check("R4 ready not yet", STAT, 32'h0);
    wait_cyc(1);
    check("R4 ready after startup", STAT, 32'h1);
    wr(CTRL, 32'h9000_0001);
    check("R8 cal ignored when enabled", CTRL, 32'h1000_0001);
    wr(CTRL, 32'h1000_0011);
    check("R6 stop ignored without start", CTRL, 32'h1000_0001);

    // R6 start/stop, R9 zero-writes
    wr(CTRL, 32'h1000_0004);
    check("R6 start set", CTRL, 32'h1000_0005);
    wr(CTRL, 32'h1000_0000);
    check("R9 start/enable kept", CTRL, 32'h1000_0005);
    wr(CTRL, 32'h1000_0002);
    check("R5 disable ignored while started", CTRL, 32'h1000_0005);
    wr(CTRL, 32'h1000_0010);
    check("R6 stop pending", CTRL, 32'h1000_0015);
    wait_cyc(STOPC - 1);
    check("R6 stop still pending", CTRL, 32'h1000_0015);
    wait_cyc(1);
    check("R6 stop done", CTRL, 32'h1000_0001);

    // R5 disable
    wr(CTRL, 32'h1000_0002);
    check("R5 disable pending", CTRL, 32'h1000_0003);
    wait_cyc(DISC - 1);
    check("R5 disable still pending", CTRL, 32'h1000_0003);
    wait_cyc(1);
    check("R5 disabled", CTRL, 32'h1000_0000);
    check("R5 ready cleared", STAT, 32'h0);

    // R4 ready write-one-to-clear
    wr(CTRL, 32'h1000_0001);
    wait_cyc(STARTUP);
    check("R4 ready again", STAT, 32'h1);
    wr(STAT, 32'h0);
    check("R4 write 0 keeps ready", STAT, 32'h1);
    wr(STAT, 32'h1);
    check("R4 ready cleared by W1C", STAT, 32'h0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      report();
      $finish;
    end
  end
endmodule